// File: doc/BRIEF.md
# CPU Memory Bank Mapper

This block sits between an 8-bit CPU bus with a 16-bit address space and two memories: a small boot ROM and a 128 KB RAM built as a lower and an upper 64 KB bank. For every memory cycle it decides which memory answers. It also produces the 17-bit physical RAM address and the ROM address. The decision is purely combinational from the current address, the strobes and two internal control bits.

The CPU changes the mapping with I/O writes to fixed port numbers. One control bit, the upper-bank bit, moves the CPU space onto the upper RAM bank. The other, the RAM-only bit, takes the ROM out of the map. Together they give four maps over three address windows. The low window spans 0x0000 to 0x3FFF, the middle window 0x4000 to 0xDFFF and the top window 0xE000 to 0xFFFF. In the low window, reads and writes can be steered to different memories, so code can run from ROM while writing the RAM underneath it. The top window can be held in the lower bank as a shared area.

Top module: `cpu_bank_mapper`

## Requirements
- R1: While `rst_n` is low, and after it rises, both control bits are clear and the boot map of R6 applies.
- R2: An I/O write (`io_req` and `wr` high at a rising clock edge) to port 0x68 sets the upper-bank bit. The new map applies from the following cycle.
- R3: An I/O write to port 0x70 or to port 0x78 clears the upper-bank bit.
- R4: An I/O write to port 0xE0 sets the RAM-only bit, and an I/O write to port 0xF0 clears it.
- R5: The following leave both control bits unchanged: an I/O write to any other 8-bit port, an I/O read to a control port, and a memory cycle whose address low byte equals a control port.
- R6: Boot map (both bits clear). Low-window reads select ROM. Low-window writes, and all accesses to the middle and top windows, go to the lower RAM bank.
- R7: RAM-only map (RAM-only set, upper-bank clear). Every window maps to the lower RAM bank for reads and writes, and ROM is never selected.
- R8: Upper map (upper-bank set, RAM-only clear). Low-window reads select ROM. Low-window writes and all middle and top accesses go to the upper RAM bank.
- R9: Split map (both bits set). Low and middle windows go to the upper RAM bank, while the top window goes to the lower RAM bank.
- R10: `ram_addr` is {bank, addr[15:0]}, with bank 0 for lower and 1 for upper. `rom_addr` is addr[11:0], so the 4 KB image repeats across the 16 KB low window.
- R11: A memory write never selects ROM. `ram_we` is high exactly on a memory write, and a write takes priority when `rd` and `wr` are both high.
- R12: With `mem_req` low, `rom_sel`, `ram_sel` and `ram_we` are all low. `rom_sel` and `ram_sel` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both control bits |
| addr | input | 16 | CPU address bus |
| mem_req | input | 1 | Memory cycle qualifier |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| io_req | input | 1 | I/O cycle qualifier |
| io_addr | input | 8 | Low byte of the I/O port address |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 17 | Physical RAM address |
| rom_addr | output | 12 | ROM address |

## Verification
The assertions check on every cycle that an idle bus selects nothing, that ROM and RAM are never selected together, and that a write never reaches ROM. They also check that the control bits move only on a qualified write to their own ports, and that the split map keeps the top window in the lower bank. Only the bench scenarios can show the full window-by-window contents of all four maps, the ROM image repeating at the window's upper end, the use of both clear ports, and a reset that arrives in the middle of a non-boot map.

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper #(
  parameter logic [7:0] PORT_HI_SET   = 8'h68,
  parameter logic [7:0] PORT_HI_CLR_A = 8'h70,
  parameter logic [7:0] PORT_HI_CLR_B = 8'h78,
  parameter logic [7:0] PORT_RO_SET   = 8'hE0,
  parameter logic [7:0] PORT_RO_CLR   = 8'hF0,
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              mem_req,
  input  logic              rd,
  input  logic              wr,
  input  logic              io_req,
  input  logic [7:0]        io_addr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [16:0]       ram_addr,
  output logic [ROM_AW-1:0] rom_addr
);

  logic hi_q, ro_q;
  logic io_wr;

  assign io_wr = io_req & wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      ro_q <= 1'b0;
    end else if (io_wr) begin
      if (io_addr == PORT_HI_SET) hi_q <= 1'b1;
      else if (io_addr == PORT_HI_CLR_A || io_addr == PORT_HI_CLR_B) hi_q <= 1'b0;
      if (io_addr == PORT_RO_SET) ro_q <= 1'b1;
      else if (io_addr == PORT_RO_CLR) ro_q <= 1'b0;
    end
  end

  logic win_low, win_top, is_read, bank;

  assign win_low = (addr[15:14] == 2'b00);
  assign win_top = (addr[15:13] == 3'b111);
  assign is_read = rd & ~wr;

  always_comb begin
    if (win_top) bank = hi_q & ~ro_q;
    else         bank = hi_q;
  end

  assign rom_sel  = mem_req & is_read & win_low & ~ro_q;
  assign ram_sel  = mem_req & (rd | wr) & ~rom_sel;
  assign ram_we   = mem_req & wr;
  assign ram_addr = {bank, addr};
  assign rom_addr = addr[ROM_AW-1:0];

endmodule

// File: rtl/cpu_bank_mapper_chk.sv
module cpu_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        mem_req,
  input logic        wr,
  input logic        io_req,
  input logic [7:0]  io_addr,
  input logic        rom_sel,
  input logic        ram_sel,
  input logic        ram_we,
  input logic [16:0] ram_addr,
  input logic        hi_q,
  input logic        ro_q
);

  logic ctl_port;
  assign ctl_port = io_addr == 8'h68 || io_addr == 8'h70 || io_addr == 8'h78 ||
                    io_addr == 8'hE0 || io_addr == 8'hF0;

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (!rom_sel && !ram_sel && !ram_we));

  a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}));

  a_r11_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !rom_sel);

  a_r5_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && wr && ctl_port) |=> ($stable(hi_q) && $stable(ro_q)));

  a_r2_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && wr && io_addr == 8'h68) |=> hi_q);

  a_r4_ro_set: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && wr && io_addr == 8'hE0) |=> ro_q);

  a_r7_no_rom_when_ram_only: assert property (@(posedge clk) disable iff (!rst_n)
    ro_q |-> !rom_sel);

  a_r9_top_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q && ro_q && ram_sel && addr[15:13] == 3'b111) |-> !ram_addr[16]);

endmodule

bind cpu_bank_mapper cpu_bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .wr(wr),
  .io_req(io_req), .io_addr(io_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
  .ram_we(ram_we), .ram_addr(ram_addr), .hi_q(hi_q), .ro_q(ro_q)
);

// File: tb/test_cpu_bank_mapper.sv
module test_cpu_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mem_req = 1'b0, rd = 1'b0, wr = 1'b0, io_req = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        rom_sel, ram_sel, ram_we;
  logic [16:0] ram_addr;
  logic [11:0] rom_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cpu_bank_mapper i_cpu_bank_mapper (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .rd(rd), .wr(wr),
    .io_req(io_req), .io_addr(io_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .ram_we(ram_we), .ram_addr(ram_addr), .rom_addr(rom_addr)
  );

  task automatic io_cycle(input logic [7:0] port, input logic is_wr);
    @(negedge clk);
    io_req = 1'b1; io_addr = port; wr = is_wr; rd = ~is_wr;
    @(negedge clk);
    io_req = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  // rom expected -> ram_sel 0; ram expected -> bank checked
  task automatic mem(input string req, input logic [15:0] a, input logic r, input logic w,
                     input logic e_rom, input logic e_ram, input logic e_bank);
    logic e_we;
    @(negedge clk);
    mem_req = 1'b1; addr = a; rd = r; wr = w;
    #2;
    e_we = w;
    n_chk++;
    if (rom_sel !== e_rom || ram_sel !== e_ram || ram_we !== e_we ||
        (e_ram && ram_addr !== {e_bank, a}) || (e_rom && rom_addr !== a[11:0])) begin
      n_bad++;
      $display("FAIL %s addr=%h: got rom=%b ram=%b we=%b ra=%h romA=%h, exp rom=%b ram=%b we=%b ra=%h romA=%h",
               req, a, rom_sel, ram_sel, ram_we, ram_addr, rom_addr,
               e_rom, e_ram, e_we, {e_bank, a}, a[11:0]);
    end
    mem_req = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic t_reset;
    #3;
    n_chk++;
    if (rom_sel !== 1'b0 || ram_sel !== 1'b0 || ram_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle in reset: rom=%b ram=%b we=%b exp 0 0 0", rom_sel, ram_sel, ram_we);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_boot(input string req);
    mem(req, 16'h0000, 1, 0, 1, 0, 0);
    mem("R10", 16'h3FFF, 1, 0, 1, 0, 0);
    mem("R10", 16'h1234, 1, 0, 1, 0, 0);
    mem(req, 16'h2000, 0, 1, 0, 1, 0);
    mem(req, 16'h8000, 1, 0, 0, 1, 0);
    mem(req, 16'hF000, 0, 1, 0, 1, 0);
  endtask

  task automatic t_ram_only;
    io_cycle(8'hE0, 1);
    mem("R7", 16'h0100, 1, 0, 0, 1, 0);
    mem("R7", 16'h0100, 0, 1, 0, 1, 0);
    mem("R7", 16'h9000, 1, 0, 0, 1, 0);
    mem("R7", 16'hE000, 1, 0, 0, 1, 0);
  endtask

  task automatic t_split;
    io_cycle(8'h68, 1);
    mem("R9", 16'h0100, 1, 0, 0, 1, 1);
    mem("R9", 16'h3000, 0, 1, 0, 1, 1);
    mem("R9", 16'h4000, 1, 0, 0, 1, 1);
    mem("R9", 16'hDFFF, 0, 1, 0, 1, 1);
    mem("R9", 16'hFFFF, 1, 0, 0, 1, 0);
    mem("R9", 16'hE000, 0, 1, 0, 1, 0);
  endtask

  task automatic t_upper;
    io_cycle(8'hF0, 1);
    mem("R8", 16'h0000, 1, 0, 1, 0, 0);
    mem("R8", 16'h0000, 0, 1, 0, 1, 1);
    mem("R8", 16'h5000, 1, 0, 0, 1, 1);
    mem("R8", 16'hE000, 1, 0, 0, 1, 1);
    mem("R11", 16'h0040, 1, 1, 0, 1, 1);
  endtask

  task automatic t_clear_ports;
    io_cycle(8'h78, 1);
    mem("R3", 16'h0010, 0, 1, 0, 1, 0);
    io_cycle(8'h68, 1);
    mem("R2", 16'h0010, 0, 1, 0, 1, 1);
    io_cycle(8'h70, 1);
    mem("R3", 16'h0010, 0, 1, 0, 1, 0);
  endtask

  task automatic t_ignored;
    io_cycle(8'h69, 1);
    io_cycle(8'h60, 1);
    io_cycle(8'hE1, 1);
    io_cycle(8'h68, 0);
    io_cycle(8'hE0, 0);
    mem("R5", 16'h0068, 0, 1, 0, 1, 0);
    mem("R5", 16'h00E0, 0, 1, 0, 1, 0);
    mem("R5", 16'h0020, 0, 1, 0, 1, 0);
    mem("R5", 16'h0020, 1, 0, 1, 0, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    mem_req = 1'b0; addr = 16'h0000; rd = 1'b1; wr = 1'b0;
    #2;
    n_chk++;
    if (rom_sel !== 1'b0 || ram_sel !== 1'b0 || ram_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 idle: rom=%b ram=%b we=%b exp 0 0 0", rom_sel, ram_sel, ram_we);
    end
    wr = 1'b1; rd = 1'b0;
    #2;
    n_chk++;
    if (ram_we !== 1'b0 || ram_sel !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 idle write: ram=%b we=%b exp 0 0", ram_sel, ram_we);
    end
    wr = 1'b0;
  endtask

  task automatic t_reset_midway;
    io_cycle(8'h68, 1);
    io_cycle(8'hE0, 1);
    mem("R9", 16'h0000, 1, 0, 0, 1, 1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_boot("R1");
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_boot("R6");
    t_ram_only();
    t_split();
    t_upper();
    t_clear_ports();
    t_ignored();
    t_idle();
    t_reset_midway();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule